// File: doc/BRIEF.md
# Processor debug entry controller

This block decides when a small pipelined processor core stops running and enters debug state. It combines four sources of debug entry. The first is an external request line. The second is a software request bit held in a one-bit control register. The third is a data watchpoint input, and the fourth is an instruction breakpoint input. Each source is qualified by the pipeline events that make it legal to act on.

A breakpoint does not stop the core at once. It is attached as a tag to the fetched instruction and travels down a shadow chain that moves whenever the core pipeline advances. Only a tag that arrives in the execute stage stops the core. Tags that are flushed on the way are discarded. A watchpoint stops the core straight after the data access it was sampled on. A request, from either the external line or the control bit, waits until the current instruction reports that it has completed.

While halted, the block raises a debug acknowledge level and a halt command and records which cause was taken. A restart input leaves debug state. A separate pulse reports that the instruction in execute one cycle earlier passed its condition codes and ran.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: `intDbgReq` is the OR of `extDbgReq` and the control request bit. The control request bit is loaded from `ctrlWrReq` at a clock edge where `ctrlWrEn` is high, and it is visible on `ctrlReqBit` after that edge.
- R2: While `intDbgReq` is high, debug state is entered at the edge of a cycle in which `exComplete` is high, and never before that. `dbgAck` rises after that edge and `entryCause` reads 2'b11.
- R3: `instBkpt` is sampled in the cycle after `instReqStrobe` and becomes the tag of the fetched instruction. Each `pipeAdvance` moves tags one stage along a chain of `PIPE_DEPTH` stages, and the last stage is execute. When a tag reaches execute, debug state is entered at the next edge with `entryCause` 2'b10.
- R4: `pipeFlush` clears every tag, including a tag sampled but not yet advanced. A flushed tag never causes debug entry.
- R5: `dataWpt` is sampled in the cycle after `dataReqStrobe`. When it is high there, debug state is entered at that edge with `entryCause` 2'b01. `dataWpt` high in any other cycle is ignored.
- R6: `dbgAck` and `coreHalt` are high exactly while the block is in debug state.
- R7: While `dbgEnable` is low, no breakpoint is sampled and no watchpoint or request causes debug entry. `intDbgReq` still shows the OR of R1.
- R8: `instExecuted` is high for the one cycle after a cycle in which both `exComplete` and `exCondPass` were high, and low otherwise.
- R9: When several causes can be taken in the same cycle, the watchpoint wins, then the breakpoint, then the request.
- R10: `restart` in debug state drops `dbgAck` and `coreHalt` at the next edge and sets `entryCause` to 2'b00. While in debug state, every new watchpoint, breakpoint or request is ignored and `entryCause` holds its value.
- R11: After reset the block is out of debug state, `entryCause` is 2'b00, the control request bit is 0 and every tag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbgEnable | input | 1 | Global debug enable |
| extDbgReq | input | 1 | External debug request |
| ctrlWrEn | input | 1 | Write strobe for the control request bit |
| ctrlWrReq | input | 1 | Value written to the control request bit |
| instReqStrobe | input | 1 | Instruction memory request cycle |
| instBkpt | input | 1 | Breakpoint flag, sampled the cycle after `instReqStrobe` |
| dataReqStrobe | input | 1 | Data memory request cycle |
| dataWpt | input | 1 | Watchpoint flag, sampled the cycle after `dataReqStrobe` |
| pipeAdvance | input | 1 | Pipeline moves one stage toward execute |
| pipeFlush | input | 1 | Pipeline discards the instructions not yet executed |
| exComplete | input | 1 | Instruction in execute completes this cycle |
| exCondPass | input | 1 | Instruction in execute passed its condition codes |
| restart | input | 1 | Leave debug state |
| intDbgReq | output | 1 | Combined debug request |
| dbgAck | output | 1 | High while in debug state |
| coreHalt | output | 1 | Halt command to the core |
| instExecuted | output | 1 | Previous-cycle instruction passed its condition codes and executed |
| ctrlReqBit | output | 1 | Current value of the control request bit |
| entryCause | output | 2 | Cause taken: 00 none, 01 watchpoint, 10 breakpoint, 11 request |

## Verification
A watchpoint hit can fall in the same cycle as a completing instruction with the external request high. The bench provokes this by raising the data strobe, then asserting the watchpoint, the external request and `exComplete` together in the next cycle. It judges the result by the single entry that follows, which must report the watchpoint cause while `intDbgReq` stays high. A second overlap is an instruction retiring in the same cycle that a request is taken. Here the bench checks that the `instExecuted` pulse and the debug entry both appear after the same edge.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WPT  = 2'b01,
    CAUSE_BKPT = 2'b10,
    CAUSE_REQ  = 2'b11
  } entry_cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTags;   // debug entry: drop every pending tag
  } ctrl_strb_t;

  // qualified hit levels from datapath to control
  typedef struct packed {
    logic wptHit;
    logic bkptHit;
    logic reqLevel;
  } hit_t;

endpackage

// File: rtl/dbg_entry_path.sv
module dbg_entry_path
  import dbg_entry_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbgEnable,
  input  logic       extDbgReq,
  input  logic       ctrlWrEn,
  input  logic       ctrlWrReq,
  input  logic       instReqStrobe,
  input  logic       instBkpt,
  input  logic       dataReqStrobe,
  input  logic       dataWpt,
  input  logic       pipeAdvance,
  input  logic       pipeFlush,
  input  logic       exComplete,
  input  logic       exCondPass,
  input  ctrl_strb_t ctrlStrb,
  output hit_t       hits,
  output logic       intDbgReq,
  output logic       instExecuted,
  output logic       ctrlReqBit
);

  localparam int LAST = PIPE_DEPTH - 1;

  logic instPendQ, dataPendQ, fetchTagQ, swReqQ, execDoneQ;
  logic [PIPE_DEPTH-1:0] tagQ;
  logic tagClear, bkptSample;

  assign tagClear   = pipeFlush | ctrlStrb.clrTags;
  assign bkptSample = instPendQ & dbgEnable & instBkpt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instPendQ <= 1'b0;
      dataPendQ <= 1'b0;
      swReqQ    <= 1'b0;
      execDoneQ <= 1'b0;
    end else begin
      instPendQ <= instReqStrobe;
      dataPendQ <= dataReqStrobe;
      execDoneQ <= exComplete & exCondPass;
      if (ctrlWrEn) swReqQ <= ctrlWrReq;
    end
  end

  // tag of the most recently fetched instruction, not yet in the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fetchTagQ <= 1'b0;
    else if (tagClear)      fetchTagQ <= 1'b0;
    else if (instPendQ)     fetchTagQ <= bkptSample;
    else if (pipeAdvance)   fetchTagQ <= 1'b0;
  end

  generate
    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
      logic feed;
      if (s == 0) begin : g_head
        assign feed = fetchTagQ;
      end else begin : g_body
        assign feed = tagQ[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tagQ[s] <= 1'b0;
        else if (tagClear)    tagQ[s] <= 1'b0;
        else if (pipeAdvance) tagQ[s] <= feed;
      end
    end
  endgenerate

  assign intDbgReq     = extDbgReq | swReqQ;
  assign ctrlReqBit    = swReqQ;
  assign instExecuted  = execDoneQ;
  assign hits.wptHit   = dataPendQ & dataWpt & dbgEnable;
  assign hits.bkptHit  = tagQ[LAST] & dbgEnable;
  assign hits.reqLevel = intDbgReq & exComplete & dbgEnable;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    pipeFlush |=> !hits.bkptHit) else $error("flushed tag reached execute"); // R4
  AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    instExecuted |=> !instExecuted || $past(exComplete)) else $error("exec pulse without completion"); // R8

endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dbgEnable,
  input  logic         restart,
  input  hit_t         hits,
  output ctrl_strb_t   ctrlStrb,
  output logic         inDebug,
  output entry_cause_e cause
);

  logic takeAny;
  entry_cause_e nextCause;

  always_comb begin
    nextCause = CAUSE_NONE;
    if (hits.wptHit)        nextCause = CAUSE_WPT;
    else if (hits.bkptHit)  nextCause = CAUSE_BKPT;
    else if (hits.reqLevel) nextCause = CAUSE_REQ;
  end

  assign takeAny          = !inDebug && (nextCause != CAUSE_NONE);
  assign ctrlStrb.clrTags = takeAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inDebug <= 1'b0;
      cause   <= CAUSE_NONE;
    end else if (inDebug) begin
      if (restart) begin
        inDebug <= 1'b0;
        cause   <= CAUSE_NONE;
      end
    end else if (takeAny) begin
      inDebug <= 1'b1;
      cause   <= nextCause;
    end
  end

  AST_ENTRY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inDebug) |-> cause != CAUSE_NONE) else $error("entry without cause"); // R6
  AST_ENTRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inDebug) |-> $past(dbgEnable)) else $error("entry while disabled"); // R7
  AST_WPT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inDebug && hits.wptHit) |=> cause == CAUSE_WPT) else $error("watchpoint lost priority"); // R9
  AST_RESTART_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (inDebug && restart) |=> !inDebug && cause == CAUSE_NONE) else $error("restart ignored"); // R10
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (inDebug && !restart) |=> inDebug && $stable(cause)) else $error("cause changed in debug"); // R10

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbgEnable,
  input  logic       extDbgReq,
  input  logic       ctrlWrEn,
  input  logic       ctrlWrReq,
  input  logic       instReqStrobe,
  input  logic       instBkpt,
  input  logic       dataReqStrobe,
  input  logic       dataWpt,
  input  logic       pipeAdvance,
  input  logic       pipeFlush,
  input  logic       exComplete,
  input  logic       exCondPass,
  input  logic       restart,
  output logic       intDbgReq,
  output logic       dbgAck,
  output logic       coreHalt,
  output logic       instExecuted,
  output logic       ctrlReqBit,
  output logic [1:0] entryCause
);

  ctrl_strb_t   ctrlStrb;
  hit_t         hits;
  logic         inDebug;
  entry_cause_e cause;

  dbg_entry_path #(.PIPE_DEPTH(PIPE_DEPTH)) u_path (
    .clk(clk), .rst_n(rst_n), .dbgEnable(dbgEnable), .extDbgReq(extDbgReq),
    .ctrlWrEn(ctrlWrEn), .ctrlWrReq(ctrlWrReq),
    .instReqStrobe(instReqStrobe), .instBkpt(instBkpt),
    .dataReqStrobe(dataReqStrobe), .dataWpt(dataWpt),
    .pipeAdvance(pipeAdvance), .pipeFlush(pipeFlush),
    .exComplete(exComplete), .exCondPass(exCondPass),
    .ctrlStrb(ctrlStrb), .hits(hits), .intDbgReq(intDbgReq),
    .instExecuted(instExecuted), .ctrlReqBit(ctrlReqBit)
  );

  dbg_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dbgEnable(dbgEnable), .restart(restart),
    .hits(hits), .ctrlStrb(ctrlStrb), .inDebug(inDebug), .cause(cause)
  );

  assign dbgAck     = inDebug;
  assign coreHalt   = inDebug;
  assign entryCause = cause;

endmodule

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbgEnable = 0, extDbgReq = 0, ctrlWrEn = 0, ctrlWrReq = 0;
  logic instReqStrobe = 0, instBkpt = 0, dataReqStrobe = 0, dataWpt = 0;
  logic pipeAdvance = 0, pipeFlush = 0, exComplete = 0, exCondPass = 0, restart = 0;
  logic intDbgReq, dbgAck, coreHalt, instExecuted, ctrlReqBit;
  logic [1:0] entryCause;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_entry_ctrl #(.PIPE_DEPTH(2)) uut (.*);

  // inputs: en ext we wd is bk ds wp adv fl cp cd rs | expected: ack cause ireq iexe
  localparam logic [17:0] VEC [NROWS] = '{
    {13'b1000000000000, 5'b00000}, // 0 idle
    {13'b1000001000000, 5'b00000}, // 1 data strobe
    {13'b1000000100000, 5'b10100}, // 2 R5 watchpoint taken
    {13'b1000000000001, 5'b00000}, // 3 R10 restart
    {13'b1000000100000, 5'b00000}, // 4 R5 stray watchpoint
    {13'b1000000000110, 5'b00001}, // 5 R8 executed
    {13'b1000000000100, 5'b00000}, // 6 R8 condition failed
    {13'b1100000000000, 5'b00010}, // 7 R2 waits for completion
    {13'b1100000000110, 5'b11111}, // 8 R2 taken with exec pulse
    {13'b1000000000001, 5'b00000}, // 9 R10 restart
    {13'b1011000000000, 5'b00010}, // 10 R1 set control bit
    {13'b1010000000000, 5'b00000}, // 11 R1 clear control bit
    {13'b1000100000000, 5'b00000}, // 12 fetch
    {13'b1000010000000, 5'b00000}, // 13 R3 tag sampled
    {13'b1000000010000, 5'b00000}, // 14 advance
    {13'b1000000010000, 5'b00000}, // 15 tag in execute
    {13'b1000000000000, 5'b11000}, // 16 R3 breakpoint taken
    {13'b1000000000001, 5'b00000}, // 17 restart
    {13'b1000100000000, 5'b00000}, // 18 fetch
    {13'b1000010000000, 5'b00000}, // 19 tag sampled
    {13'b1000000010000, 5'b00000}, // 20 advance
    {13'b1000000001000, 5'b00000}, // 21 R4 flush
    {13'b1000000010000, 5'b00000}, // 22 advance
    {13'b1000000010000, 5'b00000}, // 23 advance
    {13'b1000000000000, 5'b00000}, // 24 R4 no halt
    {13'b1000001000000, 5'b00000}, // 25 data strobe
    {13'b1100000100100, 5'b10110}, // 26 R9 watchpoint beats request
    {13'b1000001000000, 5'b10100}, // 27 strobe while halted
    {13'b1000000100000, 5'b10100}, // 28 R10 ignored in debug
    {13'b1000000000001, 5'b00000}, // 29 restart
    {13'b0000001000000, 5'b00000}, // 30 disabled strobe
    {13'b0000000100000, 5'b00000}, // 31 R7 watchpoint ignored
    {13'b0100000000100, 5'b00010}, // 32 R7 request ignored
    {13'b1000000000000, 5'b00000}  // 33 idle
  };

  function automatic string rowReq(int r);
    case (r)
      2, 4, 1:           return "R5";
      3, 9, 29:          return "R10";
      5, 6:              return "R8";
      7, 8:              return "R2";
      10, 11:            return "R1";
      12, 13, 14, 15, 16, 17: return "R3";
      18, 19, 20, 21, 22, 23, 24: return "R4";
      25, 26:            return "R9";
      27, 28:            return "R10";
      30, 31, 32:        return "R7";
      default:           return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(logic [12:0] v);
    {dbgEnable, extDbgReq, ctrlWrEn, ctrlWrReq, instReqStrobe, instBkpt,
     dataReqStrobe, dataWpt, pipeAdvance, pipeFlush, exComplete, exCondPass, restart} = v;
  endtask

  task automatic step(logic [12:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", dbgAck, 0, "ack in reset");
    check("R11", entryCause, 0, "cause in reset");
    check("R11", ctrlReqBit, 0, "control bit in reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      step(VEC[r][17:5]);
      check(rowReq(r), dbgAck, VEC[r][4], $sformatf("row %0d ack", r));
      check("R6", coreHalt, VEC[r][4], $sformatf("row %0d halt", r));
      check(rowReq(r), entryCause, VEC[r][3:2], $sformatf("row %0d cause", r));
      check("R1", intDbgReq, VEC[r][1], $sformatf("row %0d request", r));
      check("R8", instExecuted, VEC[r][0], $sformatf("row %0d executed", r));
    end

    // R3: sample and advance in the same cycle, tag follows the sampled instruction
    step(13'b1000100000000);
    step(13'b1000010010000);   // tag sampled, old (empty) tag advanced
    step(13'b1000000010000);   // tag to stage 0
    check("R3", dbgAck, 0, "tag not yet in execute");
    step(13'b1000000010000);   // tag to execute
    step(13'b1000000000000);
    check("R3", entryCause, 2'b10, "breakpoint after overlapped sample");
    step(13'b1000000000001);

    // R11: reset clears debug state, control bit and pending tags
    step(13'b1011100000000);   // set control bit, fetch
    step(13'b1010010000000);   // tag sampled
    step(13'b1000000010000);   // tag to stage 0
    @(negedge clk);
    drive(13'b0);
    rst_n = 1'b0;
    #1;
    check("R11", ctrlReqBit, 0, "control bit after reset");
    check("R11", dbgAck, 0, "ack after reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(13'b1000000010000);
    step(13'b1000000010000);
    step(13'b1000000000000);
    check("R11", dbgAck, 0, "tags cleared by reset");
    check("R1", intDbgReq, 0, "request low after reset");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule